// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Flags

This block is the multiply and accumulate datapath of a small fixed-point DSP core. It holds two 16-bit operand registers X and Y, a 32-bit product register P and a 32-bit accumulator A. The product is always a signed product scaled by two. P is refreshed whenever software writes X or Y, so a value written into either operand register is reflected in P one cycle later without any explicit multiply.

Two commands drive the accumulator. A command carries two 16-bit operands, supplied by the surrounding core after its operand fetch. A multiply-load command clears A and loads P with the doubled product of its operands. A multiply-accumulate command first adds the product already held in P into A, then loads P with the new doubled product. This lets a filter loop issue one command per tap, with the product of the previous tap accumulated while the current tap's product is formed. Negative, overflow, zero and carry flags are reported in fixed bit positions of a 16-bit status word.

A command is presented by raising `cmd_valid` for one cycle. The unit accepts one command every cycle and never applies back-pressure, so it has no ready signal. Register write strobes are plain single-cycle pulses.

Top module: `mac_flags_unit`

## Requirements
- R1: After reset, P, A and the whole status word read zero.
- R2: When `x_we` or `y_we` is high and `cmd_valid` is low, in the next cycle the written register holds `wdata` and P equals 2·X·Y computed from the new register values. If both strobes are high, X and Y both take `wdata`.
- R3: The doubled product is the low 32 bits of twice the signed 16×16 product. For example, −32768 × −32768 gives 0x80000000.
- R4: A command with `cmd_op`=0 (multiply-load) makes A zero and P = 2·`cmd_a`·`cmd_b` in the next cycle. It leaves the flags N=0, V=0, Z=1 and L=0.
- R5: A command with `cmd_op`=1 (multiply-accumulate) makes A = old A + old P (modulo 2^32) and P = 2·`cmd_a`·`cmd_b` in the next cycle.
- R6: After a multiply-accumulate, the flags reflect the addition. N is bit 31 of the new A. Z is set when the new A is zero. V is set on signed overflow. L is the carry out of the unsigned 32-bit add. The status word has N at bit 15, V at bit 14, Z at bit 13 and L at bit 12; bits 11 to 0 read zero.
- R7: Commands do not change X or Y.
- R8: Register writes and idle cycles leave A and the flags unchanged.
- R9: When a command and a register write occur in the same cycle, P takes the command's product, and the write still updates its register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| x_we | input | 1 | Write strobe for operand register X |
| y_we | input | 1 | Write strobe for operand register Y |
| wdata | input | 16 | Data for X/Y writes |
| cmd_valid | input | 1 | Command present this cycle (always accepted) |
| cmd_op | input | 1 | 0 = multiply-load, 1 = multiply-accumulate |
| cmd_a | input | 16 | First signed command operand |
| cmd_b | input | 16 | Second signed command operand |
| p_o | output | 32 | Product register P |
| a_o | output | 32 | Accumulator A |
| stat_o | output | 16 | Status word: N bit 15, V bit 14, Z bit 13, L bit 12 |

## Verification
The multiply is exercised with small positive operands, mixed signs, and the most negative operand squared. These cases separate a signed multiply from an unsigned one and expose a missing or misplaced doubling. Accumulate chains are arranged so that the sum reaches each flag condition on its own. Positive plus positive wraps to set V without L. Negative plus negative sets both L and V. Opposite signs cancel to set Z with L. The chains also show whether the old or the new product is added. Operand registers are revealed after commands through a later write, which distinguishes a command that clobbers X or Y from one that does not.

// File: rtl/mac_flags_pkg.sv
package mac_flags_pkg;
  typedef enum logic {
    OP_LOAD  = 1'b0,
    OP_ACCUM = 1'b1
  } mac_op_e;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic l;
  } mac_flags_t;

  localparam mac_flags_t FLAGS_CLEARED_ACC = '{n: 1'b0, v: 1'b0, z: 1'b1, l: 1'b0};
endpackage

// File: rtl/mac_dbl_mul.sv
module mac_dbl_mul #(
  parameter int unsigned OPW = 16,
  localparam int unsigned PW = 2 * OPW
) (
  input  logic [OPW-1:0] op_a,
  input  logic [OPW-1:0] op_b,
  output logic [PW-1:0]  prod
);
  logic signed [PW-1:0] full;

  assign full = $signed(op_a) * $signed(op_b);
  // scale by two; the top bit of the full product drops out
  assign prod = {full[PW-2:0], 1'b0};
endmodule

// File: rtl/mac_acc_add.sv
module mac_acc_add
  import mac_flags_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] acc,
  input  logic [AW-1:0] addend,
  output logic [AW-1:0] sum,
  output mac_flags_t    flg
);
  logic [AW:0] wide;

  assign wide  = {1'b0, acc} + {1'b0, addend};
  assign sum   = wide[AW-1:0];
  assign flg.n = wide[AW-1];
  assign flg.z = ~|wide[AW-1:0];
  assign flg.l = wide[AW];
  assign flg.v = (acc[AW-1] == addend[AW-1]) && (wide[AW-1] != acc[AW-1]);
endmodule

// File: rtl/mac_flags_unit.sv
module mac_flags_unit
  import mac_flags_pkg::*;
#(
  parameter int unsigned OPW = 16,
  parameter int unsigned STW = 16,
  localparam int unsigned AW  = 2 * OPW,
  localparam int unsigned N_BIT = STW - 1,
  localparam int unsigned V_BIT = STW - 2,
  localparam int unsigned Z_BIT = STW - 3,
  localparam int unsigned L_BIT = STW - 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           x_we,
  input  logic           y_we,
  input  logic [OPW-1:0] wdata,
  input  logic           cmd_valid,
  input  logic           cmd_op,
  input  logic [OPW-1:0] cmd_a,
  input  logic [OPW-1:0] cmd_b,
  output logic [AW-1:0]  p_o,
  output logic [AW-1:0]  a_o,
  output logic [STW-1:0] stat_o
);
  logic [OPW-1:0] x_q, y_q;
  logic [AW-1:0]  p_q, a_q;
  mac_flags_t     flags_q;

  logic [OPW-1:0] mul_a, mul_b;
  logic [AW-1:0]  prod, acc_sum;
  mac_flags_t     acc_flags;
  logic           is_accum;

  assign is_accum = (mac_op_e'(cmd_op) == OP_ACCUM);

  // a command owns the multiplier; otherwise it sees the post-write registers
  always_comb begin
    if (cmd_valid) begin
      mul_a = cmd_a;
      mul_b = cmd_b;
    end else begin
      mul_a = x_we ? wdata : x_q;
      mul_b = y_we ? wdata : y_q;
    end
  end

  mac_dbl_mul #(.OPW(OPW)) mul_i (
    .op_a (mul_a),
    .op_b (mul_b),
    .prod (prod)
  );

  mac_acc_add #(.AW(AW)) add_i (
    .acc    (a_q),
    .addend (p_q),
    .sum    (acc_sum),
    .flg    (acc_flags)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q     <= '0;
      y_q     <= '0;
      p_q     <= '0;
      a_q     <= '0;
      flags_q <= '0;
    end else begin
      if (x_we) x_q <= wdata;
      if (y_we) y_q <= wdata;
      if (cmd_valid || x_we || y_we) p_q <= prod;
      if (cmd_valid) begin
        if (is_accum) begin
          a_q     <= acc_sum;
          flags_q <= acc_flags;
        end else begin
          a_q     <= '0;
          flags_q <= FLAGS_CLEARED_ACC;
        end
      end
    end
  end

  always_comb begin
    stat_o        = '0;
    stat_o[N_BIT] = flags_q.n;
    stat_o[V_BIT] = flags_q.v;
    stat_o[Z_BIT] = flags_q.z;
    stat_o[L_BIT] = flags_q.l;
  end

  assign p_o = p_q;
  assign a_o = a_q;

  // R4
  load_zero_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_op |=> (a_o == '0) && stat_o[Z_BIT] && !stat_o[N_BIT]
                             && !stat_o[V_BIT] && !stat_o[L_BIT]);

  // R5
  accum_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op |=> a_o == AW'($past(a_o) + $past(p_o)));

  // R6
  accum_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op |=> (stat_o[N_BIT] == a_o[AW-1]) && (stat_o[Z_BIT] == (a_o == '0)));

  // R8
  idle_acc_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(a_o) && $stable(stat_o));

  // R2
  p_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid && !x_we && !y_we |=> $stable(p_o));
endmodule

// File: tb/mac_flags_unit_tb_top.sv
`timescale 1ns/1ps
module mac_flags_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        x_we = 1'b0, y_we = 1'b0;
  logic [15:0] wdata = '0;
  logic        cmd_valid = 1'b0, cmd_op = 1'b0;
  logic [15:0] cmd_a = '0, cmd_b = '0;
  logic [31:0] p_o, a_o;
  logic [15:0] stat_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model state
  logic [15:0] mx = '0, my = '0;
  logic [31:0] mp = '0, ma = '0;
  logic mn = 0, mv = 0, mz = 0, ml = 0;

  always #10 clk = ~clk;

  mac_flags_unit dut_i (
    .clk(clk), .rst_n(rst_n), .x_we(x_we), .y_we(y_we), .wdata(wdata),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_a(cmd_a), .cmd_b(cmd_b),
    .p_o(p_o), .a_o(a_o), .stat_o(stat_o)
  );

  // vector format: {op, a, b}; op 0 = load, 1 = accumulate
  localparam int NV = 14;
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 16'h0003, 16'h0004},
    {1'b1, 16'hFFFE, 16'h0005},
    {1'b1, 16'h1234, 16'h8000},
    {1'b1, 16'h0000, 16'h0000},
    {1'b0, 16'h7FFF, 16'h7FFF},
    {1'b1, 16'h7FFF, 16'h7FFF},
    {1'b1, 16'h0000, 16'h0000},
    {1'b0, 16'h8000, 16'h7FFF},
    {1'b1, 16'h8000, 16'h7FFF},
    {1'b1, 16'h0000, 16'h0000},
    {1'b0, 16'h0001, 16'h0001},
    {1'b1, 16'hFFFF, 16'h0001},
    {1'b1, 16'h0000, 16'h0000},
    {1'b0, 16'h8000, 16'h8000}
  };

  function automatic logic [31:0] dbl(input logic [15:0] a, input logic [15:0] b);
    logic signed [31:0] pr;
    pr = $signed(a) * $signed(b);
    return pr << 1;
  endfunction

  function automatic logic [15:0] mstat();
    return {mn, mv, mz, ml, 12'h000};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%08h expected=%08h", req, what, act, exp);
    end
  endtask

  task automatic wr(input bit wx, input bit wy, input logic [15:0] d);
    @(negedge clk);
    x_we = wx; y_we = wy; wdata = d;
    @(negedge clk);
    x_we = 0; y_we = 0;
    if (wx) mx = d;
    if (wy) my = d;
    mp = dbl(mx, my);
  endtask

  task automatic cmd(input bit op, input logic [15:0] a, input logic [15:0] b,
                     input bit wx, input logic [15:0] xd);
    logic [32:0] s;
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_a = a; cmd_b = b; x_we = wx; wdata = xd;
    @(negedge clk);
    cmd_valid = 0; x_we = 0;
    if (op) begin
      s  = {1'b0, ma} + {1'b0, mp};
      mv = (ma[31] == mp[31]) && (s[31] != ma[31]);
      ma = s[31:0];
      mn = s[31]; mz = (s[31:0] == 0); ml = s[32];
    end else begin
      ma = 0; mn = 0; mv = 0; mz = 1; ml = 0;
    end
    mp = dbl(a, b);
    if (wx) mx = xd;
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "P after reset", p_o, 0);
    chk("R1", "A after reset", a_o, 0);
    chk("R1", "status after reset", {16'h0, stat_o}, 0);

    wr(1, 0, 16'h0100);
    chk("R2", "P after X write", p_o, mp);
    wr(0, 1, 16'hFFFD);
    chk("R2", "P after Y write (mixed sign)", p_o, 32'hFFFFFA00);
    chk("R8", "status after writes", {16'h0, stat_o}, {16'h0, mstat()});
    wr(1, 1, 16'h0003);
    chk("R2", "P after dual write", p_o, 32'd18);

    for (int i = 0; i < NV; i++) begin
      cmd(VEC[i][32], VEC[i][31:16], VEC[i][15:0], 0, 16'h0);
      if (VEC[i][32]) begin
        chk("R5", "A after accumulate", a_o, ma);
        chk("R5", "P after accumulate", p_o, mp);
        chk("R6", "status after accumulate", {16'h0, stat_o}, {16'h0, mstat()});
      end else begin
        chk("R4", "A after load", a_o, 0);
        chk("R4", "P after load", p_o, mp);
        chk("R4", "status after load", {16'h0, stat_o}, 32'h2000);
      end
    end
    chk("R3", "most negative squared", p_o, 32'h80000000);

    // directed flag corners from hand-worked values
    cmd(0, 16'h7FFF, 16'h7FFF, 0, 0);
    cmd(1, 16'h7FFF, 16'h7FFF, 0, 0);
    cmd(1, 16'h0000, 16'h0000, 0, 0);
    chk("R6", "positive wrap sets N,V", {16'h0, stat_o}, 32'hC000);
    cmd(0, 16'h8000, 16'h7FFF, 0, 0);
    cmd(1, 16'h8000, 16'h7FFF, 0, 0);
    cmd(1, 16'h0000, 16'h0000, 0, 0);
    chk("R6", "negative wrap A", a_o, 32'h00020000);
    chk("R6", "negative wrap sets V,L", {16'h0, stat_o}, 32'h5000);
    cmd(0, 16'h0001, 16'h0001, 0, 0);
    cmd(1, 16'hFFFF, 16'h0001, 0, 0);
    cmd(1, 16'h0000, 16'h0000, 0, 0);
    chk("R6", "cancel sets Z,L", {16'h0, stat_o}, 32'h3000);

    // R7: X and Y survive commands (X=Y=3 from the dual write)
    wr(0, 1, 16'h0002);
    chk("R7", "P reveals X kept", p_o, 32'd12);

    // R9: command and X write together
    cmd(0, 16'h0005, 16'h0007, 1, 16'h0010);
    chk("R9", "P takes command product", p_o, 32'd70);
    wr(0, 1, 16'h0001);
    chk("R9", "P reveals X written", p_o, 32'd32);

    // R8: A and flags held across writes and idle
    cmd(0, 16'h0100, 16'h0100, 0, 0);
    cmd(1, 16'h0000, 16'h0000, 0, 0);
    wr(1, 0, 16'h1111);
    repeat (3) @(negedge clk);
    chk("R8", "A held", a_o, ma);
    chk("R8", "status held", {16'h0, stat_o}, {16'h0, mstat()});
    chk("R8", "A value", a_o, 32'h00020000);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule